// File: doc/BRIEF.md
# Bank Select Register with Write-Sequence Configuration

This block holds the bank number of an auxiliary memory card and sits behind one write-only I/O location. Every byte stored there normally becomes the new bank number. A small sequencer watches the same byte stream for a fixed six-byte unlock pattern. Once the pattern is complete, the next two writes are read as a command and its argument. The command can set a capacity mask, set an LED enable, or force the bank to its top value. Software can therefore reach the configuration without decoding a second address.

The bank number sent on to the memory is the stored bank ANDed with the capacity mask, so unpopulated banks alias onto populated ones. It is presented only while the alternate zero-page/auxiliary enable input is high and reads zero otherwise. If the card stays idle for too long, a partly entered pattern is dropped.

Top module: `bank_cfg_reg`

## Requirements
- R1: A synchronous active-high reset sets the stored bank to 0x00, the capacity mask to 0xFF and the LED enable to 1, and drives `bank_out` to 0x00.
- R2: Every write (`wr_en` high at a clock edge) loads `wr_data` as the stored bank, except in the case R6 describes. From that same edge, `bank_out` shows the new effective bank.
- R3: The unlock pattern is six back-to-back writes of 0xFF, 0x00, 0x55, 0xAA, 0xC1, 0xAD, in that order. The write after it is the command byte, and the write after that is the argument byte.
- R4: Command 0xE0 stores its argument as the capacity mask. The effective bank is then `stored bank AND mask`.
- R5: Command 0xE2 stores bit 0 of its argument as the LED enable, which drives `led_on`.
- R6: Command 0xFF leaves the stored bank at 0xFF after its argument write, in place of the argument value. The mask still applies.
- R7: The command write and the argument write each advance the sequencer whatever their value. After the argument the sequencer returns to idle. A command code with no meaning changes neither the mask nor the LED enable, and two writes of 0x00 flush a sequence that is waiting for its command.
- R8: A byte that does not match during the unlock phase returns the sequencer to idle. If that byte is 0xFF, it counts as the first unlock byte.
- R9: If `TIMEOUT` consecutive clock cycles pass with no write, the sequencer goes back to idle (default 65536). A gap of `TIMEOUT-1` idle cycles keeps the sequence alive.
- R10: While `aux_en` is low at a clock edge, `bank_out` is 0x00 after that edge. The stored bank, mask and LED enable are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle strobe: write to the bank address |
| wr_data | input | 8 | Byte written |
| aux_en | input | 1 | Alternate zero-page / auxiliary access enable |
| bank_out | output | 8 | Registered effective bank (masked, gated by aux_en) |
| led_on | output | 1 | Registered LED enable |

## Verification
The assertions assume that `wr_en` is a clean one-cycle-per-byte strobe and that `wr_data` is valid whenever `wr_en` is high. They also assume that reset is held for at least one edge before any checking starts. The stimulus drives inputs only on falling edges, raises `wr_en` for exactly one cycle per byte and asserts reset from time zero. It runs with a short `TIMEOUT` so that gaps of exactly `TIMEOUT-1` and `TIMEOUT` idle cycles can both be reached.

// File: rtl/bank_cfg_pkg.sv
package bank_cfg_pkg;
  localparam int DW      = 8;
  localparam int KEY_LEN = 6;
  localparam int STEP_W  = 3;

  typedef logic [STEP_W-1:0] step_t;

  localparam step_t STEP_IDLE = step_t'(0);
  localparam step_t STEP_LAST = step_t'(KEY_LEN - 1);
  localparam step_t STEP_CMD  = step_t'(KEY_LEN);
  localparam step_t STEP_ARG  = step_t'(KEY_LEN + 1);

  function automatic logic [DW-1:0] key_byte(input int idx);
    case (idx)
      0:       key_byte = 8'hFF;
      1:       key_byte = 8'h00;
      2:       key_byte = 8'h55;
      3:       key_byte = 8'hAA;
      4:       key_byte = 8'hC1;
      default: key_byte = 8'hAD;
    endcase
  endfunction
endpackage

// File: rtl/unlock_seq.sv
module unlock_seq
  import bank_cfg_pkg::*;
#(
  parameter int TIMEOUT = 65536
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output step_t         step_q,
  output logic [DW-1:0] cmd_q,
  output logic          fire
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);
  localparam int HW = 1 << STEP_W;

  logic [HW-1:0] hit;
  logic [CW-1:0] idle_cnt;
  step_t         step_nxt;

  for (genvar g = 0; g < HW; g++) begin : g_key
    if (g < KEY_LEN) begin : g_cmp
      assign hit[g] = (wr_data == key_byte(g));
    end else begin : g_none
      assign hit[g] = 1'b0;
    end
  end

  assign fire = wr_en && (step_q == STEP_ARG);

  always_comb begin
    step_nxt = STEP_IDLE;
    if (step_q == STEP_CMD) begin
      step_nxt = STEP_ARG;
    end else if (step_q == STEP_ARG) begin
      step_nxt = STEP_IDLE;
    end else if (hit[step_q]) begin
      step_nxt = step_t'(step_q + step_t'(1));
    end else if (wr_data == key_byte(0)) begin
      step_nxt = step_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q   <= STEP_IDLE;
      cmd_q    <= '0;
      idle_cnt <= '0;
    end else if (wr_en) begin
      step_q   <= step_nxt;
      idle_cnt <= '0;
      if (step_q == STEP_CMD) cmd_q <= wr_data;
    end else begin
      if (idle_cnt == CNT_LAST) step_q <= STEP_IDLE;
      else idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import bank_cfg_pkg::*;
#(
  parameter logic [DW-1:0] CMD_MASK = 8'hE0,
  parameter logic [DW-1:0] CMD_LED  = 8'hE2,
  parameter logic [DW-1:0] CMD_TOP  = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          aux_en,
  input  logic          fire,
  input  logic [DW-1:0] cmd,
  output logic [DW-1:0] bank_q,
  output logic [DW-1:0] mask_q,
  output logic          led_q,
  output logic [DW-1:0] out_q
);
  logic [DW-1:0] bank_nxt, mask_nxt;
  logic          led_nxt;

  always_comb begin
    bank_nxt = bank_q;
    mask_nxt = mask_q;
    led_nxt  = led_q;
    if (wr_en) begin
      bank_nxt = wr_data;
      if (fire) begin
        case (cmd)
          CMD_MASK: mask_nxt = wr_data;
          CMD_LED:  led_nxt  = wr_data[0];
          CMD_TOP:  bank_nxt = '1;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      mask_q <= '1;
      led_q  <= 1'b1;
      out_q  <= '0;
    end else begin
      bank_q <= bank_nxt;
      mask_q <= mask_nxt;
      led_q  <= led_nxt;
      out_q  <= aux_en ? (bank_nxt & mask_nxt) : '0;
    end
  end
endmodule

// File: rtl/bank_cfg_reg.sv
module bank_cfg_reg
  import bank_cfg_pkg::*;
#(
  parameter int            TIMEOUT  = 65536,
  parameter logic [DW-1:0] CMD_MASK = 8'hE0,
  parameter logic [DW-1:0] CMD_LED  = 8'hE2,
  parameter logic [DW-1:0] CMD_TOP  = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          aux_en,
  output logic [DW-1:0] bank_out,
  output logic          led_on
);
  step_t         seq_step;
  logic [DW-1:0] seq_cmd;
  logic          seq_fire;
  logic [DW-1:0] bank_reg;
  logic [DW-1:0] mask_reg;

  unlock_seq #(.TIMEOUT(TIMEOUT)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .step_q  (seq_step),
    .cmd_q   (seq_cmd),
    .fire    (seq_fire)
  );

  cfg_regs #(
    .CMD_MASK (CMD_MASK),
    .CMD_LED  (CMD_LED),
    .CMD_TOP  (CMD_TOP)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .aux_en  (aux_en),
    .fire    (seq_fire),
    .cmd     (seq_cmd),
    .bank_q  (bank_reg),
    .mask_q  (mask_reg),
    .led_q   (led_on),
    .out_q   (bank_out)
  );
endmodule

// File: rtl/bank_cfg_chk.sv
module bank_cfg_chk
  import bank_cfg_pkg::*;
#(
  parameter int            TIMEOUT  = 65536,
  parameter logic [DW-1:0] CMD_MASK = 8'hE0,
  parameter logic [DW-1:0] CMD_TOP  = 8'hFF
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          aux_en,
  input logic [DW-1:0] bank_out,
  input logic          led_on,
  input step_t         seq_step,
  input logic [DW-1:0] seq_cmd,
  input logic [DW-1:0] bank_reg,
  input logic [DW-1:0] mask_reg
);
  localparam int GW = $clog2(TIMEOUT + 1) + 1;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst || wr_en) gap <= '0;
    else if (int'(gap) < TIMEOUT) gap <= gap + 1'b1;
  end

  // R1
  reset_values_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bank_out == '0 && led_on && mask_reg == '1 && bank_reg == '0));

  // R3
  unlock_done_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && seq_step == STEP_LAST && wr_data == 8'hAD) |=> seq_step == STEP_CMD);

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && seq_step == STEP_ARG && seq_cmd == CMD_MASK) |=> mask_reg == $past(wr_data));

  // R6
  top_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && seq_step == STEP_ARG && seq_cmd == CMD_TOP) |=> bank_reg == '1);

  // R7
  cmd_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && seq_step == STEP_CMD) |=> seq_step == STEP_ARG);

  // R7
  arg_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && seq_step == STEP_ARG) |=> seq_step == STEP_IDLE);

  // R9
  idle_timeout_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(gap) >= TIMEOUT) |-> seq_step == STEP_IDLE);

  // R10
  aux_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !aux_en |=> bank_out == '0);
endmodule

bind bank_cfg_reg bank_cfg_chk #(
  .TIMEOUT  (TIMEOUT),
  .CMD_MASK (CMD_MASK),
  .CMD_TOP  (CMD_TOP)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .aux_en   (aux_en),
  .bank_out (bank_out),
  .led_on   (led_on),
  .seq_step (seq_step),
  .seq_cmd  (seq_cmd),
  .bank_reg (bank_reg),
  .mask_reg (mask_reg)
);

// File: tb/sim_bank_cfg_reg.sv
`timescale 1ns/1ps
module sim_bank_cfg_reg;
  localparam int TO = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       aux_en = 1'b1;
  logic [7:0] bank_out;
  logic       led_on;

  int total = 0;
  int bad = 0;
  string cur_tag = "R1";
  bit running = 1'b0;

  always #2 clk = ~clk;

  bank_cfg_reg #(.TIMEOUT(TO)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .aux_en(aux_en), .bank_out(bank_out), .led_on(led_on)
  );

  // behavioural reference
  int key[6] = '{255, 0, 85, 170, 193, 173};
  int m_bank, m_mask, m_led, m_step, m_cmd, m_cnt, m_out;

  always @(posedge clk) begin
    if (rst) begin
      m_bank = 0; m_mask = 255; m_led = 1; m_step = 0; m_cmd = 0; m_cnt = 0; m_out = 0;
    end else begin
      if (wr_en) begin
        int d;
        d = int'(wr_data);
        m_cnt = 0;
        m_bank = d;
        if (m_step < 6) begin
          if (d == key[m_step]) m_step = m_step + 1;
          else if (d == 255) m_step = 1;
          else m_step = 0;
        end else if (m_step == 6) begin
          m_cmd = d; m_step = 7;
        end else begin
          m_step = 0;
          if (m_cmd == 224) m_mask = d;
          else if (m_cmd == 226) m_led = d % 2;
          else if (m_cmd == 255) m_bank = 255;
        end
      end else if (m_cnt == TO - 1) begin
        m_step = 0;
      end else begin
        m_cnt = m_cnt + 1;
      end
      m_out = aux_en ? (m_bank & m_mask) : 0;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      total++;
      if (int'(bank_out) != m_out || int'(led_on) != m_led) begin
        bad++;
        $display("FAIL %s model: bank_out=%h led=%0d expected bank_out=%h led=%0d",
                 cur_tag, bank_out, led_on, m_out[7:0], m_led);
      end
    end
  end

  task automatic expect_out(input logic [7:0] eb, input logic el, input string tag);
    total++;
    if (bank_out !== eb || led_on !== el) begin
      bad++;
      $display("FAIL %s direct: bank_out=%h led=%0b expected bank_out=%h led=%0b",
               tag, bank_out, led_on, eb, el);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    for (int i = 0; i < 6; i++) wr(8'(key[i]));
  endtask

  task automatic cmd(input logic [7:0] c, input logic [7:0] a);
    unlock(); wr(c); wr(a);
  endtask

  task automatic finish_run();
    running = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog: state=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    running = 1'b1;
    expect_out(8'h00, 1'b1, "R1");

    cur_tag = "R2";
    wr(8'h5A); expect_out(8'h5A, 1'b1, "R2");
    wr(8'hC3); expect_out(8'hC3, 1'b1, "R2");

    cur_tag = "R4";
    cmd(8'hE0, 8'h0F); expect_out(8'h0F, 1'b1, "R3");
    wr(8'h3A); expect_out(8'h0A, 1'b1, "R4");

    cur_tag = "R5";
    cmd(8'hE2, 8'h00); expect_out(8'h00, 1'b0, "R5");
    cmd(8'hE2, 8'h01); expect_out(8'h01, 1'b1, "R5");

    cur_tag = "R6";
    cmd(8'hE0, 8'hFF); expect_out(8'hFF, 1'b1, "R4");
    cmd(8'hFF, 8'h00); expect_out(8'hFF, 1'b1, "R6");
    cmd(8'hE0, 8'h3C);
    cmd(8'hFF, 8'h00); expect_out(8'h3C, 1'b1, "R6");
    cmd(8'hE0, 8'hFF);

    cur_tag = "R7";
    cmd(8'h77, 8'h12); expect_out(8'h12, 1'b1, "R7");
    unlock(); wr(8'h00); wr(8'h00);
    wr(8'hE2); wr(8'h00); expect_out(8'h00, 1'b1, "R7");

    cur_tag = "R8";
    wr(8'hFF); wr(8'h00); wr(8'hFF); wr(8'h00); wr(8'h55);
    wr(8'hAA); wr(8'hC1); wr(8'hAD); wr(8'hE2); wr(8'h00);
    expect_out(8'h00, 1'b0, "R8");
    wr(8'hFF); wr(8'h00); wr(8'h55); wr(8'h12); wr(8'hAA);
    wr(8'hC1); wr(8'hAD); wr(8'hE2); wr(8'h01);
    expect_out(8'h01, 1'b0, "R8");

    cur_tag = "R9";
    unlock(); idle(TO - 1); wr(8'hE2); wr(8'h01);
    expect_out(8'h01, 1'b1, "R9");
    unlock(); idle(TO); wr(8'hE2); wr(8'h00);
    expect_out(8'h00, 1'b1, "R9");

    cur_tag = "R10";
    aux_en = 1'b0; wr(8'h44); expect_out(8'h00, 1'b1, "R10");
    aux_en = 1'b1; idle(1); expect_out(8'h44, 1'b1, "R10");

    idle(2);
    finish_run();
  end
endmodule